// File: doc/BRIEF.md
# In-Band Interrupt Request Sequencer

This block lives inside the target side of an I3C interface. It turns a software request into an in-band interrupt. Software pulses a request strobe and supplies a mandatory data byte, up to four payload bytes and a payload-source select. The block samples the eligibility flags once, at the start of the request. If the request is not allowed, it refuses outright and reports "not attempted". If it is allowed, the block passes a byte sequence to the bus engine below it: first the address byte, then the mandatory byte, then the payload.

The bus engine takes bytes through a valid/ready handshake. For each byte it returns one response, either acknowledged or terminated. The block counts the payload bytes the controller accepted and posts a 2-bit status code, a byte count and a one-cycle status interrupt. At the same time it clears the request bit in hardware. If the controller terminates the transfer early, the sequencer freezes in a halt state. It leaves that state only after software reports a flushed transmit FIFO and then writes resume. Unsent bytes are never sent again.

Top module: `ibi_sequencer`

## Requirements
- R1: A `reqSet` pulse while the block is idle sets `reqBit` on the next clock edge. Hardware clears `reqBit` in the same cycle that `statusIrq` goes high.
- R2: The bytes are presented in this order: address byte `{dynAddr,1'b1}`, then `mandByte`, then payload bytes. Payload byte k is `payloadData[8k+7:8k]`, lowest byte first. All values are latched at the request.
- R3: The payload byte count depends on the select. With `srcSel` = 2'b00 it is min(`payloadLen`, 4). With any other `srcSel` value no payload bytes are sent.
- R4: When every byte is acknowledged, the status is 2'b00 and `respLen` equals the payload byte count.
- R5: When the controller refuses the address byte (response with `rspAck`=0), the status is 2'b01 and `respLen` is 0. No further byte is offered and the block does not halt.
- R6: The request is refused with status 2'b11, `respLen` 0 and no `txValid` in any of these cases:
  - `dynAddrValid` is low (no address assigned, or the address was cleared);
  - `ibiEnable` is low;
  - `roleIsController` is high.
- R7: The eligibility flags are sampled only on the request edge. Changing them later does not affect a request in flight.
- R8: A terminated response to the mandatory byte or to a payload byte gives status 2'b10, and `respLen` is the number of payload bytes acknowledged before it. `halted` then goes high.
- R9: While halted, a `resumeWr` pulse is ignored until a `flushDone` pulse has been seen. `txValid` stays low while halted. After resume, nothing is retransmitted.
- R10: A `reqSet` pulse is ignored while a request is in flight or while the block is halted.
- R11: `statusIrq` is a single-cycle pulse, once per status update.
- R12: While `txValid` is high and `txReady` is low, `txValid` stays high and `txByte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqSet | input | 1 | Software request pulse |
| mandByte | input | 8 | Mandatory data byte |
| payloadData | input | 32 | Payload bytes, byte 0 in the low bits |
| payloadLen | input | 3 | Requested payload count (clamped to 4) |
| srcSel | input | 2 | Payload source select (2'b00 = payload register) |
| dynAddr | input | 7 | Assigned dynamic address |
| dynAddrValid | input | 1 | Dynamic address is assigned |
| ibiEnable | input | 1 | Interrupts enabled by the controller |
| roleIsController | input | 1 | Device has taken the controller role |
| txValid | output | 1 | Byte offered to the bus engine |
| txByte | output | 8 | Byte offered |
| txReady | input | 1 | Bus engine takes the byte |
| rspValid | input | 1 | Response for the last byte taken |
| rspAck | input | 1 | 1 = acknowledged, 0 = refused or terminated |
| statusCode | output | 2 | 00 ok, 01 address refused, 10 early end, 11 not attempted |
| respLen | output | 3 | Payload bytes acknowledged |
| statusIrq | output | 1 | Status-updated pulse |
| reqBit | output | 1 | Request bit as seen by software |
| halted | output | 1 | Frozen after early termination |
| flushDone | input | 1 | Software has flushed the transmit FIFO |
| resumeWr | input | 1 | Software resume write |

## Verification
A wrong byte index shows up at once on `txByte`, on the first handshake after the fault. A miscounted payload shows up in `respLen` at the status pulse. Both appear within a few cycles of the controller response that exposes them. A stuck or skipped control state has other symptoms:
- a missing or repeated `statusIrq`;
- `reqBit` left set;
- `halted` not clearing after the flush-then-resume order.

These show up at the end of the same request, or when the next request is refused.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_NACK   = 2'b01,
    ST_TERM   = 2'b10,
    ST_NOTATT = 2'b11
  } ibiStatus_e;

  typedef struct packed {
    logic       load;
    logic       advance;
    logic       countPay;
    logic       post;
    ibiStatus_e code;
  } ctrlStrobe_t;
endpackage

// File: rtl/ibi_datapath.sv
module ibi_datapath
  import ibi_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAY_BYTES = 4,
  localparam int BYTE_W   = ADDR_W + 1,
  localparam int IDX_W    = $clog2(PAY_BYTES + 2),
  localparam int CNT_W    = $clog2(PAY_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [BYTE_W-1:0]           mandByte,
  input  logic [BYTE_W*PAY_BYTES-1:0] payloadData,
  input  logic [CNT_W-1:0]            payloadLen,
  input  logic [1:0]                  srcSel,
  input  logic [ADDR_W-1:0]           dynAddr,
  input  logic                        dynAddrValid,
  input  logic                        ibiEnable,
  input  logic                        roleIsController,
  output logic [BYTE_W-1:0]           txByte,
  output logic                        isAddrByte,
  output logic                        isPayByte,
  output logic                        isLastByte,
  output logic                        eligible,
  output logic                        reqBit,
  output logic [1:0]                  statusCode,
  output logic [CNT_W-1:0]            respLen,
  output logic                        statusIrq
);
  logic [ADDR_W-1:0]           addrQ;
  logic [BYTE_W-1:0]           mdbQ;
  logic [BYTE_W*PAY_BYTES-1:0] payQ;
  logic [CNT_W-1:0]            nPayQ, cntQ, lenClamp, nPayNext;
  logic [IDX_W-1:0]            idxQ;
  logic [BYTE_W-1:0]           payByte;
  logic                        eligQ;

  always_comb begin
    lenClamp = (payloadLen > CNT_W'(PAY_BYTES)) ? CNT_W'(PAY_BYTES) : payloadLen;
    nPayNext = (srcSel == 2'b00) ? lenClamp : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; mdbQ <= '0; payQ <= '0; nPayQ <= '0; eligQ <= 1'b0;
      idxQ <= '0; cntQ <= '0;
    end else if (strobe.load) begin
      addrQ <= dynAddr;
      mdbQ  <= mandByte;
      payQ  <= payloadData;
      nPayQ <= nPayNext;
      eligQ <= dynAddrValid && ibiEnable && !roleIsController;
      idxQ  <= '0;
      cntQ  <= '0;
    end else begin
      if (strobe.advance)  idxQ <= idxQ + IDX_W'(1);
      if (strobe.countPay) cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit <= 1'b0; statusCode <= 2'b00; respLen <= '0; statusIrq <= 1'b0;
    end else begin
      statusIrq <= strobe.post;
      if (strobe.load) reqBit <= 1'b1;
      if (strobe.post) begin
        reqBit     <= 1'b0;
        statusCode <= strobe.code;
        respLen    <= cntQ;
      end
    end
  end

  always_comb begin
    payByte = '0;
    for (int k = 0; k < PAY_BYTES; k++)
      if (idxQ == IDX_W'(k + 2)) payByte = payQ[k*BYTE_W +: BYTE_W];
    if (idxQ == '0)               txByte = {addrQ, 1'b1};
    else if (idxQ == IDX_W'(1))   txByte = mdbQ;
    else                          txByte = payByte;
  end

  assign isAddrByte = (idxQ == '0);
  assign isPayByte  = (idxQ > IDX_W'(1));
  assign isLastByte = (idxQ == IDX_W'(nPayQ) + IDX_W'(1));
  assign eligible   = eligQ;

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusIrq |=> !statusIrq);
  p_req_cleared_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusIrq |-> !reqBit);
  p_notatt_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusIrq && statusCode == ST_NOTATT) |-> respLen == '0);
  p_ok_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusIrq && statusCode == ST_OK) |-> respLen == nPayQ);
endmodule

// File: rtl/ibi_ctrl.sv
module ibi_ctrl
  import ibi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSet,
  input  logic        eligible,
  input  logic        isAddrByte,
  input  logic        isPayByte,
  input  logic        isLastByte,
  input  logic        txReady,
  input  logic        rspValid,
  input  logic        rspAck,
  input  logic        flushDone,
  input  logic        resumeWr,
  output ctrlStrobe_t strobe,
  output logic        txValid,
  output logic        halted
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_SEND, S_RESP, S_POST, S_HALT} state_e;
  state_e     stateQ, stateNext;
  ibiStatus_e codeQ, codeNext;
  logic       flushSeenQ;

  always_comb begin
    stateNext = stateQ;
    codeNext  = codeQ;
    strobe    = '{load: 1'b0, advance: 1'b0, countPay: 1'b0, post: 1'b0, code: codeQ};
    unique case (stateQ)
      S_IDLE: if (reqSet) begin
        strobe.load = 1'b1;
        stateNext   = S_EVAL;
      end
      S_EVAL: begin
        if (eligible) stateNext = S_SEND;
        else begin
          codeNext  = ST_NOTATT;
          stateNext = S_POST;
        end
      end
      S_SEND: if (txReady) stateNext = S_RESP;
      S_RESP: if (rspValid) begin
        if (isAddrByte) begin
          if (rspAck) begin
            strobe.advance = 1'b1;
            stateNext      = S_SEND;
          end else begin
            codeNext  = ST_NACK;
            stateNext = S_POST;
          end
        end else if (rspAck) begin
          strobe.countPay = isPayByte;
          if (isLastByte) begin
            codeNext  = ST_OK;
            stateNext = S_POST;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = S_SEND;
          end
        end else begin
          codeNext  = ST_TERM;
          stateNext = S_POST;
        end
      end
      S_POST: begin
        strobe.post = 1'b1;
        stateNext   = (codeQ == ST_TERM) ? S_HALT : S_IDLE;
      end
      S_HALT: if (resumeWr && flushSeenQ) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      codeQ      <= ST_OK;
      flushSeenQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      codeQ  <= codeNext;
      if (stateQ != S_HALT)  flushSeenQ <= 1'b0;
      else if (flushDone)    flushSeenQ <= 1'b1;
    end
  end

  assign txValid = (stateQ == S_SEND);
  assign halted  = (stateQ == S_HALT);

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !txValid);
  p_halt_needs_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !flushSeenQ) |=> halted);
endmodule

// File: rtl/ibi_sequencer.sv
module ibi_sequencer
  import ibi_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAY_BYTES = 4,
  localparam int BYTE_W   = ADDR_W + 1,
  localparam int CNT_W    = $clog2(PAY_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqSet,
  input  logic [BYTE_W-1:0]           mandByte,
  input  logic [BYTE_W*PAY_BYTES-1:0] payloadData,
  input  logic [CNT_W-1:0]            payloadLen,
  input  logic [1:0]                  srcSel,
  input  logic [ADDR_W-1:0]           dynAddr,
  input  logic                        dynAddrValid,
  input  logic                        ibiEnable,
  input  logic                        roleIsController,
  output logic                        txValid,
  output logic [BYTE_W-1:0]           txByte,
  input  logic                        txReady,
  input  logic                        rspValid,
  input  logic                        rspAck,
  output logic [1:0]                  statusCode,
  output logic [CNT_W-1:0]            respLen,
  output logic                        statusIrq,
  output logic                        reqBit,
  output logic                        halted,
  input  logic                        flushDone,
  input  logic                        resumeWr
);
  ctrlStrobe_t strobe;
  logic eligible, isAddrByte, isPayByte, isLastByte;

  ibi_ctrl u_ctrl (
    .clk, .rstN, .reqSet, .eligible, .isAddrByte, .isPayByte, .isLastByte,
    .txReady, .rspValid, .rspAck, .flushDone, .resumeWr,
    .strobe, .txValid, .halted
  );

  ibi_datapath #(.ADDR_W(ADDR_W), .PAY_BYTES(PAY_BYTES)) u_dp (
    .clk, .rstN, .strobe, .mandByte, .payloadData, .payloadLen, .srcSel,
    .dynAddr, .dynAddrValid, .ibiEnable, .roleIsController,
    .txByte, .isAddrByte, .isPayByte, .isLastByte, .eligible,
    .reqBit, .statusCode, .respLen, .statusIrq
  );

  p_byte_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txByte));
  p_req_while_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqBit && !statusIrq) |=> (reqBit || statusIrq));
endmodule

// File: tb/tb_ibi_sequencer.sv
`timescale 1ns/1ps
module tb_ibi_sequencer;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqSet = 0, txReady = 0, rspValid = 0, rspAck = 0, flushDone = 0, resumeWr = 0;
  logic [7:0] mandByte = 0;
  logic [31:0] payloadData = 0;
  logic [2:0] payloadLen = 0;
  logic [1:0] srcSel = 0;
  logic [6:0] dynAddr = 0;
  logic dynAddrValid = 0, ibiEnable = 0, roleIsController = 0;
  logic txValid, statusIrq, reqBit, halted;
  logic [7:0] txByte;
  logic [1:0] statusCode;
  logic [2:0] respLen;

  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  ibi_sequencer dut (
    .clk, .rstN, .reqSet, .mandByte, .payloadData, .payloadLen, .srcSel,
    .dynAddr, .dynAddrValid, .ibiEnable, .roleIsController,
    .txValid, .txByte, .txReady, .rspValid, .rspAck,
    .statusCode, .respLen, .statusIrq, .reqBit, .halted, .flushDone, .resumeWr
  );

  typedef struct packed {
    logic dv, en, role;
    logic [1:0] sel;
    logic [2:0] len;
    logic [5:0] mask;
    logic [1:0] eCode;
    logic [2:0] eLen;
    logic [2:0] eBytes;
    logic eHalt;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b1,1'b0,2'b00,3'd4,6'b111111,2'b00,3'd4,3'd6,1'b0}, // R4 full payload
    '{1'b1,1'b1,1'b0,2'b00,3'd0,6'b111111,2'b00,3'd0,3'd2,1'b0}, // R3 no payload
    '{1'b1,1'b1,1'b0,2'b00,3'd7,6'b111111,2'b00,3'd4,3'd6,1'b0}, // R3 clamp
    '{1'b1,1'b1,1'b0,2'b01,3'd3,6'b111111,2'b00,3'd0,3'd2,1'b0}, // R3 other select
    '{1'b1,1'b1,1'b0,2'b00,3'd4,6'b111110,2'b01,3'd0,3'd1,1'b0}, // R5 address refused
    '{1'b0,1'b1,1'b0,2'b00,3'd4,6'b111111,2'b11,3'd0,3'd0,1'b0}, // R6 no address
    '{1'b1,1'b0,1'b0,2'b00,3'd4,6'b111111,2'b11,3'd0,3'd0,1'b0}, // R6 disabled
    '{1'b1,1'b1,1'b1,2'b00,3'd4,6'b111111,2'b11,3'd0,3'd0,1'b0}, // R6 role switched
    '{1'b1,1'b1,1'b0,2'b00,3'd4,6'b101111,2'b10,3'd2,3'd5,1'b1}, // R8 mid payload
    '{1'b1,1'b1,1'b0,2'b00,3'd4,6'b111101,2'b10,3'd0,3'd2,1'b1}, // R8 at mandatory byte
    '{1'b1,1'b1,1'b0,2'b00,3'd1,6'b111011,2'b10,3'd0,3'd3,1'b1}, // R8 first payload
    '{1'b1,1'b1,1'b0,2'b00,3'd2,6'b111111,2'b00,3'd2,3'd4,1'b0}  // R4 partial count
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int idx, input logic [7:0] seed);
    logic [31:0] pay = {seed + 8'h33, seed + 8'h22, seed + 8'h11, seed};
    if (idx == 0) return {(seed[6:0] | 7'h08), 1'b1};
    if (idx == 1) return seed ^ 8'h5A;
    return pay[(idx-2)*8 +: 8];
  endfunction

  task automatic runReq(input vec_t v, input logic [7:0] seed, input bit dropEn,
                        input bit extraReq, output logic [1:0] gotCode,
                        output logic [2:0] gotLen, output int gotBytes);
    bit done = 0;
    logic [7:0] hold;
    gotBytes = 0; gotCode = 'x; gotLen = 'x;
    dynAddrValid = v.dv; ibiEnable = v.en; roleIsController = v.role;
    srcSel = v.sel; payloadLen = v.len;
    dynAddr = seed[6:0] | 7'h08; mandByte = seed ^ 8'h5A;
    payloadData = {seed + 8'h33, seed + 8'h22, seed + 8'h11, seed};
    reqSet = 1;
    @(negedge clk); reqSet = 0;
    check("R1 reqBit set", reqBit, 1);
    if (dropEn) begin ibiEnable = 0; dynAddrValid = 0; end
    for (int c = 0; c < 200 && !done; c++) begin
      @(negedge clk);
      if (statusIrq) begin
        done = 1; gotCode = statusCode; gotLen = respLen;
        check("R1 reqBit cleared with status", reqBit, 0);
        @(negedge clk);
        check("R11 single pulse", statusIrq, 0);
      end else if (txValid) begin
        if (gotBytes == 1) begin
          hold = txByte;
          @(negedge clk);
          check("R12 valid held", txValid, 1);
          check("R12 byte held", txByte, hold);
        end
        check("R2 byte order", txByte, expByte(gotBytes, seed));
        txReady = 1;
        if (extraReq && gotBytes == 0) reqSet = 1;
        @(negedge clk); txReady = 0; reqSet = 0;
        rspValid = 1; rspAck = v.mask[gotBytes];
        @(negedge clk); rspValid = 0;
        gotBytes++;
      end
    end
    ibiEnable = 1; dynAddrValid = 1; roleIsController = 0;
  endtask

  task automatic recover();
    flushDone = 1; @(negedge clk); flushDone = 0;
    resumeWr = 1;  @(negedge clk); resumeWr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [1:0] code; logic [2:0] len; int nb;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset reqBit", reqBit, 0);
    check("R11 reset irq", statusIrq, 0);
    check("R9 reset halted", halted, 0);
    check("R12 reset txValid", txValid, 0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runReq(VECS[i], 8'(i * 16 + 3), 0, 0, code, len, nb);
      check($sformatf("R4/R5/R6/R8 status v%0d", i), code, VECS[i].eCode);
      check($sformatf("R3/R4/R8 length v%0d", i), len, VECS[i].eLen);
      check($sformatf("R2/R6 byte count v%0d", i), nb, VECS[i].eBytes);
      check($sformatf("R8 halt v%0d", i), halted, VECS[i].eHalt);
      if (halted) begin
        recover();
        check("R9 resume after flush", halted, 0);
      end
    end

    // R7: flags dropped after the request edge do not matter
    runReq(VECS[0], 8'h41, 1, 0, code, len, nb);
    check("R7 status", code, 2'b00);
    check("R7 length", len, 4);

    // R10: request while in flight is ignored
    runReq(VECS[11], 8'h52, 0, 1, code, len, nb);
    check("R10 busy status", code, 2'b00);
    check("R10 busy bytes", nb, 4);
    repeat (3) @(negedge clk);
    check("R10 no second request", reqBit, 0);
    check("R10 no second irq", statusIrq, 0);

    // R9/R10: halt handling
    runReq(VECS[8], 8'h63, 0, 0, code, len, nb);
    check("R8 halt entered", halted, 1);
    resumeWr = 1; @(negedge clk); resumeWr = 0;
    repeat (2) @(negedge clk);
    check("R9 resume without flush ignored", halted, 1);
    reqSet = 1; @(negedge clk); reqSet = 0;
    @(negedge clk);
    check("R10 request during halt ignored", reqBit, 0);
    check("R9 quiet while halted", txValid, 0);
    recover();
    check("R9 halt left", halted, 0);
    begin
      int seen = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (txValid || statusIrq) seen++;
      end
      check("R9 no retransmit", seen, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule